// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the protocol layer of a bus target. It sits behind a byte-level serializer that reports start (including repeated start) and stop events, hands over each received byte, asks for the next byte to transmit, and reports whether the host acknowledged that byte. The engine answers every received byte with an acknowledge decision and supplies the transmit bytes. The serializer handles pin timing and clock stretching.

After a start, the first byte holds the 7-bit target address in bits [7:1] and the direction in bit 0 (1 = read). On a write with a matching address, the first data byte is the command. It becomes the persistent register pointer. Command bits [7:6] choose the register class: 01 is word, 10 is block, and 00 or 11 is byte. The low bits choose one of `NREGS` registers in that class, and the bits in between are ignored. Byte, word and block registers (block buffers of up to `BLK_MAX` bytes with a stored length) are read and written through this pointer. Because the pointer survives across transactions, a bare read returns the register addressed last.

The state machine has these states: IDLE, ADDR, CMD, WRITE, READ and IGNORE. A start moves any state to ADDR, and a stop moves any state to IDLE (start wins if both are present). The other transitions are:
- ADDR goes to CMD on a matching write address, to READ on a matching read address, and to IGNORE on a mismatch.
- CMD goes to WRITE when the command byte arrives.
- WRITE goes to IGNORE when a block count is too large.
- READ goes to IGNORE when the host nacks.

Top module: `smbus_reg_target`

## Requirements
- R1: An address byte whose bits [7:1] equal `DEV_ADDR` is acked. A non-matching address byte is nacked, every later byte up to the next start is nacked, and no byte is transmitted.
- R2: Every cycle with `rx_vld` high is followed in the next cycle by `ack_vld` high, carrying the decision in `ack_ok`.
- R3: The first byte written after a matching write address is acked and latched as the register pointer. Class bits [7:6] are 01 for word, 10 for block, and 00 or 11 for byte. Bits [5:IDX_W] have no effect.
- R4: A byte-class write stores the first data byte. A read of that register returns it.
- R5: Word registers are written and read low byte first, then high byte.
- R6: In a block write, the byte after the command is the count (0..`BLK_MAX`). The next count data bytes fill the buffer from position 0, and the stored length becomes the count. Every byte is acked.
- R7: A block count above `BLK_MAX` is nacked. The following bytes are nacked, and the buffer and length stay unchanged.
- R8: A block read sends the stored length first, then the stored data bytes in order.
- R9: A read with no command phase returns data of the register selected by the most recent command, in any earlier transaction.
- R10: After the host nacks a transmitted byte, no byte is sent (`tx_vld` stays low) until a new start.
- R11: In READ, a `tx_req` pulse gives `tx_vld` with `tx_data` in the next cycle. Bytes requested past the register's content read 8'hFF.
- R12: After reset, the pointer is 0, all registers and lengths are 0, and `ack_vld` and `tx_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| rx_vld | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 = ack, 0 = nack |
| tx_req | input | 1 | Serializer asks for the next byte to send |
| tx_vld | output | 1 | Transmit byte is valid |
| tx_data | output | 8 | Byte to transmit |
| host_ack_vld | input | 1 | Host acknowledge for the last sent byte is valid |
| host_nack | input | 1 | Host did not acknowledge (1 = nack) |

## Verification
The assertions check the following on every cycle: each received byte gets a decision one cycle later, transmit bytes appear only in answer to a request, a mismatched address byte is nacked, a matched one is acked, and no byte goes out between a host nack and the next start. Some behaviours are visible only over whole transactions, so the bench's scenarios cover them against a bench-side register model:
- byte order of words and blocks;
- persistence of the pointer into bare reads;
- rejection of an oversize count, leaving storage intact;
- padding past the end of a register.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [1:0] {
        CLS_BYTE  = 2'd0,
        CLS_WORD  = 2'd1,
        CLS_BLOCK = 2'd2
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } state_e;

endpackage

// File: rtl/smbt_cmd_decode.sv
module smbt_cmd_decode
    import smbt_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [7:0]       cmd,
    output cls_e             cls,
    output logic [IDX_W-1:0] sel
);

    // Bits between the class field and the index do not take part.
    logic unused_mid;
    assign unused_mid = ^cmd[5:IDX_W];

    always_comb begin
        unique case (cmd[7:6])
            2'b01:   cls = CLS_WORD;
            2'b10:   cls = CLS_BLOCK;
            default: cls = CLS_BYTE;
        endcase
    end

    assign sel = cmd[IDX_W-1:0];

endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile
    import smbt_pkg::*;
#(
    parameter int NREGS   = 4,
    parameter int BLK_MAX = 32,
    parameter int IDX_W   = 2,
    parameter int LEN_W   = 6,
    parameter int POS_W   = 7,
    parameter int BA_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel,
    input  cls_e             cls,
    input  logic             we_byte,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic             we_len,
    input  logic             we_blk,
    input  logic [BA_W-1:0]  blk_pos,
    input  logic [7:0]       wdata,
    input  logic [POS_W-1:0] rd_pos,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] cur_len
);

    logic [7:0]       byte_mem [NREGS];
    logic [15:0]      word_mem [NREGS];
    logic [LEN_W-1:0] len_mem  [NREGS];
    logic [7:0]       blk_mem  [NREGS][BLK_MAX];

    assign cur_len = len_mem[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) begin
                byte_mem[r] <= '0;
                word_mem[r] <= '0;
                len_mem[r]  <= '0;
                for (int b = 0; b < BLK_MAX; b++) begin
                    blk_mem[r][b] <= '0;
                end
            end
        end else begin
            if (we_byte) byte_mem[sel]         <= wdata;
            if (we_lo)   word_mem[sel][7:0]    <= wdata;
            if (we_hi)   word_mem[sel][15:8]   <= wdata;
            if (we_len)  len_mem[sel]          <= wdata[LEN_W-1:0];
            if (we_blk)  blk_mem[sel][blk_pos] <= wdata;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        case (cls)
            CLS_BYTE: begin
                if (rd_pos == '0) rd_data = byte_mem[sel];
            end
            CLS_WORD: begin
                if (rd_pos == POS_W'(0))      rd_data = word_mem[sel][7:0];
                else if (rd_pos == POS_W'(1)) rd_data = word_mem[sel][15:8];
            end
            CLS_BLOCK: begin
                if (rd_pos == '0)
                    rd_data = 8'(cur_len);
                else if (rd_pos <= POS_W'(cur_len))
                    rd_data = blk_mem[sel][BA_W'(rd_pos - POS_W'(1))];
            end
            default: rd_data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/smbus_reg_target.sv
module smbus_reg_target
    import smbt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NREGS    = 4,
    parameter int         BLK_MAX  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       rx_vld,
    input  logic [7:0] rx_data,
    output logic       ack_vld,
    output logic       ack_ok,
    input  logic       tx_req,
    output logic       tx_vld,
    output logic [7:0] tx_data,
    input  logic       host_ack_vld,
    input  logic       host_nack
);

    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int LEN_W = $clog2(BLK_MAX + 1);
    localparam int POS_W = LEN_W + 1;
    localparam int BA_W  = (BLK_MAX > 1) ? $clog2(BLK_MAX) : 1;
    localparam logic [POS_W-1:0] POS_SAT = '1;

    state_e           state_q, state_d;
    logic [7:0]       ptr_q;
    logic [POS_W-1:0] pos_q;
    cls_e             cls;
    logic [IDX_W-1:0] sel;
    logic [LEN_W-1:0] cur_len;
    logic [7:0]       rd_data;
    logic             we_byte, we_lo, we_hi, we_len, we_blk;
    logic             ack_d, rx_take, tx_fire, addr_hit;
    logic [BA_W-1:0]  blk_pos;

    smbt_cmd_decode #(.IDX_W(IDX_W)) u_dec (
        .cmd (ptr_q),
        .cls (cls),
        .sel (sel)
    );

    smbt_regfile #(
        .NREGS(NREGS), .BLK_MAX(BLK_MAX), .IDX_W(IDX_W),
        .LEN_W(LEN_W), .POS_W(POS_W), .BA_W(BA_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .cls     (cls),
        .we_byte (we_byte),
        .we_lo   (we_lo),
        .we_hi   (we_hi),
        .we_len  (we_len),
        .we_blk  (we_blk),
        .blk_pos (blk_pos),
        .wdata   (rx_data),
        .rd_pos  (pos_q),
        .rd_data (rd_data),
        .cur_len (cur_len)
    );

    assign addr_hit = (rx_data[7:1] == DEV_ADDR);
    assign rx_take  = rx_vld && !bus_start && !bus_stop;
    assign tx_fire  = tx_req && !bus_start && !bus_stop && (state_q == ST_READ);
    assign blk_pos  = BA_W'(pos_q - POS_W'(1));

    // Next state and write strobes.
    always_comb begin
        state_d = state_q;
        ack_d   = 1'b0;
        we_byte = 1'b0;
        we_lo   = 1'b0;
        we_hi   = 1'b0;
        we_len  = 1'b0;
        we_blk  = 1'b0;
        if (bus_start) begin
            state_d = ST_ADDR;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR: begin
                    if (rx_vld) begin
                        if (addr_hit) begin
                            ack_d   = 1'b1;
                            state_d = rx_data[0] ? ST_READ : ST_CMD;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_CMD: begin
                    if (rx_vld) begin
                        ack_d   = 1'b1;
                        state_d = ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (rx_vld) begin
                        ack_d = 1'b1;
                        case (cls)
                            CLS_WORD: begin
                                we_lo = (pos_q == POS_W'(0));
                                we_hi = (pos_q == POS_W'(1));
                            end
                            CLS_BLOCK: begin
                                if (pos_q == '0) begin
                                    if (rx_data > 8'(BLK_MAX)) begin
                                        ack_d   = 1'b0;
                                        state_d = ST_IGNORE;
                                    end else begin
                                        we_len = 1'b1;
                                    end
                                end else if (pos_q <= POS_W'(cur_len)) begin
                                    we_blk = 1'b1;
                                end
                            end
                            default: we_byte = (pos_q == '0);
                        endcase
                    end
                end
                ST_READ: begin
                    if (host_ack_vld && host_nack) state_d = ST_IGNORE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register, pointer and byte position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CMD && rx_take) ptr_q <= rx_data;
            if (state_d != state_q)
                pos_q <= '0;
            else if (((state_q == ST_WRITE && rx_take) || tx_fire) && pos_q != POS_SAT)
                pos_q <= pos_q + POS_W'(1);
        end
    end

    // Handshake outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
            tx_vld  <= 1'b0;
            tx_data <= '0;
        end else begin
            ack_vld <= rx_vld;
            ack_ok  <= ack_d;
            tx_vld  <= tx_fire;
            if (tx_fire) tx_data <= rd_data;
        end
    end

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker #(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_start,
    input logic       rx_vld,
    input logic [7:0] rx_data,
    input logic       ack_vld,
    input logic       ack_ok,
    input logic       tx_req,
    input logic       tx_vld,
    input logic       host_ack_vld,
    input logic       host_nack
);

    logic first_q;  // next received byte is an address byte
    logic muted_q;  // host has nacked since the last start

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            muted_q <= 1'b0;
        end else begin
            first_q <= bus_start ? 1'b1 : (rx_vld ? 1'b0 : first_q);
            muted_q <= bus_start ? 1'b0 : ((host_ack_vld && host_nack) ? 1'b1 : muted_q);
        end
    end

    AST_ACK_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> ack_vld);  // R2

    AST_TX_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> $past(tx_req));  // R11

    AST_ADDR_MISS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && rx_vld && !bus_start && rx_data[7:1] != DEV_ADDR) |=> (ack_vld && !ack_ok));  // R1

    AST_ADDR_HIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && rx_vld && !bus_start && rx_data[7:1] == DEV_ADDR) |=> (ack_vld && ack_ok));  // R1

    AST_SILENT_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (muted_q && !bus_start) |=> !tx_vld);  // R10

endmodule

bind smbus_reg_target smbt_checker #(.DEV_ADDR(DEV_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_start    (bus_start),
    .rx_vld       (rx_vld),
    .rx_data      (rx_data),
    .ack_vld      (ack_vld),
    .ack_ok       (ack_ok),
    .tx_req       (tx_req),
    .tx_vld       (tx_vld),
    .host_ack_vld (host_ack_vld),
    .host_nack    (host_nack)
);

// File: tb/smbus_reg_target_tb.sv
module smbus_reg_target_tb;

    localparam logic [6:0] DEV = 7'h2A;

    logic clk = 0, rst_n = 0;
    logic bus_start = 0, bus_stop = 0, rx_vld = 0, tx_req = 0;
    logic host_ack_vld = 0, host_nack = 0;
    logic [7:0] rx_data = 0;
    logic ack_vld, ack_ok, tx_vld;
    logic [7:0] tx_data;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_byte [4];
    logic [15:0] m_word [4];
    int m_len [4];
    logic [7:0] m_blk [4][32];
    logic [7:0] m_ptr;
    logic [7:0] wbuf [40];

    always #5 clk = ~clk;

    smbus_reg_target #(.DEV_ADDR(DEV)) u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cls_of(logic [7:0] c);
        return (c[7:6] == 2'b01) ? 1 : (c[7:6] == 2'b10) ? 2 : 0;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] c, int pos);
        int r = int'(c[1:0]);
        case (cls_of(c))
            1: return (pos == 0) ? m_word[r][7:0] : (pos == 1) ? m_word[r][15:8] : 8'hFF;
            2: return (pos == 0) ? 8'(m_len[r]) : (pos <= m_len[r]) ? m_blk[r][pos-1] : 8'hFF;
            default: return (pos == 0) ? m_byte[r] : 8'hFF;
        endcase
    endfunction

    function automatic int rd_count(logic [7:0] c);
        int k = cls_of(c);
        return (k == 1) ? 2 : (k == 2) ? m_len[int'(c[1:0])] + 1 : 1;
    endfunction

    task automatic ev_start();
        @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
    endtask

    task automatic ev_stop();
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
    endtask

    task automatic put(input logic [7:0] b, output logic a);
        @(negedge clk); rx_vld = 1; rx_data = b;
        @(negedge clk); rx_vld = 0; rx_data = 0;
        check("R2 ack_vld", ack_vld, 1);
        a = ack_ok;
    endtask

    task automatic get(input logic nk, output logic v, output logic [7:0] d);
        @(negedge clk); tx_req = 1;
        @(negedge clk); tx_req = 0; v = tx_vld; d = tx_data;
        @(negedge clk); host_ack_vld = 1; host_nack = nk;
        @(negedge clk); host_ack_vld = 0; host_nack = 0;
    endtask

    // Write transaction: command then n data bytes; returns AND of acks.
    task automatic wr_txn(input logic [7:0] c, input int n, output logic all_ok);
        logic a;
        ev_start();
        put({DEV, 1'b0}, a); all_ok = a;
        put(c, a); all_ok &= a;
        for (int i = 0; i < n; i++) begin put(wbuf[i], a); all_ok &= a; end
        ev_stop();
    endtask

    task automatic model_wr(input logic [7:0] c, input int n);
        int r = int'(c[1:0]);
        m_ptr = c;
        case (cls_of(c))
            1: begin
                if (n >= 1) m_word[r][7:0] = wbuf[0];
                if (n >= 2) m_word[r][15:8] = wbuf[1];
            end
            2: if (n >= 1 && wbuf[0] <= 32) begin
                m_len[r] = int'(wbuf[0]);
                for (int i = 1; i < n; i++) if (i <= m_len[r]) m_blk[r][i-1] = wbuf[i];
            end
            default: if (n >= 1) m_byte[r] = wbuf[0];
        endcase
    endtask

    // Read transaction: optional command phase, n bytes, last one nacked.
    task automatic rd_txn(input string req, input logic use_cmd, input logic [7:0] c, input int n);
        logic a, v; logic [7:0] d;
        ev_start();
        if (use_cmd) begin
            put({DEV, 1'b0}, a); put(c, a);
            m_ptr = c;
            ev_start();
        end
        put({DEV, 1'b1}, a);
        check({req, " addr ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            get(k == n - 1, v, d);
            check(req, {v, d}, {1'b1, exp_rd(m_ptr, k)});
        end
        ev_stop();
    endtask

    task automatic fill_block(input int len, input int n);
        wbuf[0] = 8'(len);
        for (int i = 1; i < n; i++) wbuf[i] = 8'($urandom);
    endtask

    initial begin
        logic ok, a, v; logic [7:0] d, c;
        void'($urandom(32'h5EED_1234));
        for (int r = 0; r < 4; r++) begin
            m_byte[r] = 0; m_word[r] = 0; m_len[r] = 0;
            for (int b = 0; b < 32; b++) m_blk[r][b] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        check("R12 ack_vld reset", ack_vld, 0);
        check("R12 tx_vld reset", tx_vld, 0);
        rst_n = 1;
        @(negedge clk);
        rd_txn("R12 pointer 0 byte 0", 0, 0, 1);

        // R4 byte write/read, R11 padding past the byte
        wbuf[0] = 8'hA5; wr_txn(8'h01, 1, ok); model_wr(8'h01, 1);
        check("R4 write acks", ok, 1);
        rd_txn("R4 R11 byte read with pad", 1, 8'h01, 3);

        // R5 word low first; R3 middle bits ignored (0x7E selects word reg 2)
        wbuf[0] = 8'h34; wbuf[1] = 8'h12; wr_txn(8'h42, 2, ok); model_wr(8'h42, 2);
        rd_txn("R5 R3 word read", 1, 8'h7E, 2);

        // R9 bare read returns last addressed register
        rd_txn("R9 receive byte", 0, 8'h0, 2);

        // R6/R8 full-size block
        fill_block(32, 33); wr_txn(8'h83, 33, ok); model_wr(8'h83, 33);
        check("R6 block write acks", ok, 1);
        rd_txn("R8 block read", 1, 8'h83, 34);

        // R7 count over limit rejected, contents intact
        ev_start();
        put({DEV, 1'b0}, a); put(8'h83, a); m_ptr = 8'h83;
        put(8'd33, a); check("R7 count nacked", a, 0);
        put(8'h55, a); check("R7 data nacked", a, 0);
        ev_stop();
        rd_txn("R7 block unchanged", 0, 0, 34);

        // R1 address mismatch
        ev_start();
        put({7'h2B, 1'b0}, a); check("R1 miss nacked", a, 0);
        put(8'h00, a); check("R1 later byte nacked", a, 0);
        ev_stop();
        ev_start();
        put({7'h2B, 1'b1}, a);
        get(0, v, d); check("R1 no tx on miss", v, 0);
        ev_stop();

        // R10 host nack stops transmission
        ev_start();
        put({DEV, 1'b0}, a); put(8'h42, a); m_ptr = 8'h42; ev_start();
        put({DEV, 1'b1}, a);
        get(1, v, d); check("R10 first byte", {v, d}, {1'b1, 8'h34});
        get(0, v, d); check("R10 silent after nack", v, 0);
        ev_stop();

        // Random mix
        for (int it = 0; it < 70; it++) begin
            int op = int'($urandom % 6);
            c = 8'($urandom);
            case (op)
                0: begin c[7:6] = 2'b00; wbuf[0] = 8'($urandom);
                   wr_txn(c, 1, ok); model_wr(c, 1); check("R4 rnd ack", ok, 1); end
                1: begin c[7:6] = 2'b01; wbuf[0] = 8'($urandom); wbuf[1] = 8'($urandom);
                   wr_txn(c, 2, ok); model_wr(c, 2); check("R5 rnd ack", ok, 1); end
                2: begin
                    int len = int'($urandom % 33);
                    c[7:6] = 2'b10;
                    if ($urandom % 5 == 0) begin
                        fill_block(33 + int'($urandom % 200), 3);
                        wr_txn(c, 3, ok); model_wr(c, 3); check("R7 rnd reject", ok, 0);
                    end else begin
                        fill_block(len, len + 1);
                        wr_txn(c, len + 1, ok); model_wr(c, len + 1); check("R6 rnd ack", ok, 1);
                    end
                end
                3: rd_txn("R8 R3 rnd read", 1, c, rd_count(c) + 1);
                4: rd_txn("R9 rnd receive", 0, 0, rd_count(m_ptr));
                default: begin
                    ev_start();
                    put({DEV ^ 7'h01, 1'b0}, a); check("R1 rnd miss", a, 0);
                    put(c, a); check("R1 rnd ignored", a, 0);
                    ev_stop();
                end
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule